// File: doc/BRIEF.md
# Memory Power-Mode Controller

This block holds one small power-control register and turns its contents, together with the chip-select, the address decode and the bus-width mode, into per-half enable lines for a program-memory array and a data-RAM array. One register bit picks how the program array behaves while the chip is selected. With the bit clear, the array stays powered for faster access. With the bit set, the array is powered only while it is being addressed. Deasserting the chip-select puts every array into standby, whatever the register holds.

A second register bit governs a logic array. While the bit is clear, the array runs in full-power turbo mode. While it is set, an idle timer watches the array's inputs and drops the array into its zero-power state once they have held still for a window. The window length is a parameter in picoseconds, converted to clock cycles. All enables are combinational from the inputs and the registered state. Register writes take effect at the clock edge.

Top module: `mpm_ctrl`

## Requirements
- R1: After reset the register at address 0 reads 0x00: the power saver is off and turbo is on.
- R2: A write with `reg_addr` = 0 stores `wr_data[3]` as the saver bit and `wr_data[4]` as the turbo-disable bit at the clock edge. `rd_data` shows the addressed register combinationally. The other bits of address 0 read 0. Writes to any other address are ignored, and any other address reads 0x00.
- R3: While `cs_n` = 0 and the saver bit is 0, both program-array halves are enabled, whatever `prog_hit`, `bus8` and `a0` hold.
- R4: While `cs_n` = 1, all four array enables are 0, whatever the register and the decode inputs hold.
- R5: While `cs_n` = 0 and the saver bit is 1, the program array is enabled only when `prog_hit` = 1. A RAM-only access (`ram_hit` = 1, `prog_hit` = 0) leaves it off.
- R6: The RAM halves are enabled when `cs_n` = 0 and `ram_hit` = 1. Both halves are enabled unless R7 applies.
- R7: While `bus8` = 1 and the saver bit is 1, an enabled array turns on only one half: the even half when `a0` = 0 and the odd half when `a0` = 1. This applies to both the program array and the RAM.
- R8: While the turbo-disable bit is 0, `la_sleep` stays 0.
- R9: While the turbo-disable bit is 1, `la_sleep` is 1 once `la_in` has held the same value across IDLE_CYC consecutive rising edges. IDLE_CYC = ceil(IDLE_PS / CLK_PS). The count starts after reset, when the value at reset is 0.
- R10: A change of `la_in` from its value at the last edge drops `la_sleep` in that same cycle and restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| cs_n | input | 1 | Chip select, active low |
| prog_hit | input | 1 | Decode: current access targets program memory |
| ram_hit | input | 1 | Decode: current access targets data RAM |
| bus8 | input | 1 | 1 = 8-bit data bus mode |
| a0 | input | 1 | Address bit 0, picks the odd or even half |
| la_in | input | LA_W | Inputs of the logic array watched for activity |
| prog_en_even | output | 1 | Program array even half enable |
| prog_en_odd | output | 1 | Program array odd half enable |
| ram_en_even | output | 1 | RAM even half enable |
| ram_en_odd | output | 1 | RAM odd half enable |
| la_sleep | output | 1 | Logic array in zero-power state |

## Verification
The bench builds the block with LA_W = 4, ADDR_W = 2, CLK_PS = 4000 and IDLE_PS = 20000. That gives an idle window of 5 cycles, so the saturating count, its restart on a change, and sleep entry and exit can all be reached many times within a short run. The two-bit address brings writes and reads at non-zero addresses within reach. The random phase also walks every combination of select, decode, bus width and address bit under all four register settings.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  localparam int REG_W         = 8;
  localparam int SAVER_BIT     = 3;
  localparam int TURBO_OFF_BIT = 4;
  localparam int N_ARRAYS      = 2;  // 0: program array, 1: data RAM
  localparam int ARR_PROG      = 0;
  localparam int ARR_RAM       = 1;
endpackage

// File: rtl/mpm_regs.sv
module mpm_regs
  import mpm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              saver_q,
  output logic              turbo_off_q
);
  logic hit0;
  assign hit0 = (reg_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saver_q     <= 1'b0;
      turbo_off_q <= 1'b0;
    end else if (wr_en && hit0) begin
      saver_q     <= wr_data[SAVER_BIT];
      turbo_off_q <= wr_data[TURBO_OFF_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit0) begin
      rd_data[SAVER_BIT]     = saver_q;
      rd_data[TURBO_OFF_BIT] = turbo_off_q;
    end
  end
endmodule

// File: rtl/mpm_half_sel.sv
module mpm_half_sel (
  input  logic active,
  input  logic split,
  input  logic a0,
  output logic en_even,
  output logic en_odd
);
  assign en_even = active && (!split || !a0);
  assign en_odd  = active && (!split ||  a0);
endmodule

// File: rtl/mpm_idle_timer.sv
module mpm_idle_timer #(
  parameter int LA_W     = 4,
  parameter int IDLE_CYC = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [LA_W-1:0] la_in,
  output logic            sleep
);
  localparam int CNT_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYC);

  logic [LA_W-1:0]  prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             moved;

  assign moved = (la_in != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= la_in;
      if (moved)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sleep = enable && !moved && (cnt_q == CNT_MAX);
endmodule

// File: rtl/mpm_ctrl.sv
module mpm_ctrl
  import mpm_pkg::*;
#(
  parameter int LA_W    = 4,
  parameter int ADDR_W  = 2,
  parameter int CLK_PS  = 4000,
  parameter int IDLE_PS = 70000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              cs_n,
  input  logic              prog_hit,
  input  logic              ram_hit,
  input  logic              bus8,
  input  logic              a0,
  input  logic [LA_W-1:0]   la_in,
  output logic              prog_en_even,
  output logic              prog_en_odd,
  output logic              ram_en_even,
  output logic              ram_en_odd,
  output logic              la_sleep
);
  localparam int IDLE_CYC = (IDLE_PS + CLK_PS - 1) / CLK_PS;

  logic saver_q, turbo_off_q, split;
  logic [N_ARRAYS-1:0] act, en_e, en_o;

  mpm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data),
    .saver_q(saver_q), .turbo_off_q(turbo_off_q)
  );

  // Chip-select overrides everything; the saver bit gates program on its decode.
  assign act[ARR_PROG] = !cs_n && (!saver_q || prog_hit);
  assign act[ARR_RAM]  = !cs_n && ram_hit;
  assign split         = bus8 && saver_q;

  for (genvar g = 0; g < N_ARRAYS; g++) begin : g_half
    mpm_half_sel u_sel (
      .active(act[g]), .split(split), .a0(a0),
      .en_even(en_e[g]), .en_odd(en_o[g])
    );
  end

  assign prog_en_even = en_e[ARR_PROG];
  assign prog_en_odd  = en_o[ARR_PROG];
  assign ram_en_even  = en_e[ARR_RAM];
  assign ram_en_odd   = en_o[ARR_RAM];

  mpm_idle_timer #(.LA_W(LA_W), .IDLE_CYC(IDLE_CYC)) u_idle (
    .clk(clk), .rst_n(rst_n), .enable(turbo_off_q), .la_in(la_in), .sleep(la_sleep)
  );
endmodule

// File: rtl/mpm_ctrl_chk.sv
module mpm_ctrl_chk #(
  parameter int LA_W   = 4,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        wr_data,
  input logic              cs_n,
  input logic              bus8,
  input logic [LA_W-1:0]   la_in,
  input logic              prog_en_even,
  input logic              prog_en_odd,
  input logic              ram_en_even,
  input logic              ram_en_odd,
  input logic              la_sleep,
  input logic              saver_q,
  input logic              turbo_off_q
);
  // R4
  cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(prog_en_even || prog_en_odd || ram_en_even || ram_en_odd));

  // R3
  saver_off_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !saver_q) |-> (prog_en_even && prog_en_odd));

  // R7
  one_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus8 && saver_q) |-> (!(prog_en_even && prog_en_odd) && !(ram_en_even && ram_en_odd)));

  // R8
  turbo_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !turbo_off_q |-> !la_sleep);

  // R10
  wake_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (la_in != $past(la_in)) |-> !la_sleep);

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_addr == '0) |=> (turbo_off_q == $past(wr_data[4]) && saver_q == $past(wr_data[3])));
endmodule

bind mpm_ctrl mpm_ctrl_chk #(.LA_W(LA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
  .cs_n(cs_n), .bus8(bus8), .la_in(la_in),
  .prog_en_even(prog_en_even), .prog_en_odd(prog_en_odd),
  .ram_en_even(ram_en_even), .ram_en_odd(ram_en_odd),
  .la_sleep(la_sleep), .saver_q(saver_q), .turbo_off_q(turbo_off_q)
);

// File: tb/mpm_ctrl_test.sv
`timescale 1ns/1ps
module mpm_ctrl_test;
  localparam int LA_W = 4, ADDR_W = 2, CLK_PS = 4000, IDLE_PS = 20000;
  localparam int N = (IDLE_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 0, rst_n = 0, wr_en = 0, cs_n = 1, prog_hit = 0, ram_hit = 0, bus8 = 0, a0 = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [LA_W-1:0] la_in = '0;
  logic pe, po, re, ro, la_sleep;

  int vectors = 0, fails = 0;
  bit done = 0;
  bit m_saver = 0, m_toff = 0;
  logic [LA_W-1:0] m_prev = '0;
  int m_quiet = 0;

  always #2 clk = ~clk;

  mpm_ctrl #(.LA_W(LA_W), .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .IDLE_PS(IDLE_PS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .cs_n(cs_n), .prog_hit(prog_hit), .ram_hit(ram_hit), .bus8(bus8),
    .a0(a0), .la_in(la_in), .prog_en_even(pe), .prog_en_odd(po),
    .ram_en_even(re), .ram_en_odd(ro), .la_sleep(la_sleep));

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: state update on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_saver = 0; m_toff = 0; m_prev = '0; m_quiet = 0;
    end else begin
      if (wr_en && reg_addr == 0) begin m_saver = wr_data[3]; m_toff = wr_data[4]; end
      if (la_in != m_prev) m_quiet = 0;
      else if (m_quiet < N) m_quiet++;
      m_prev = la_in;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) if (rst_n) begin
    bit pact, ract, split, moved;
    int exp_pe, exp_po, exp_re, exp_ro, exp_rd;
    string ptag, rtag, stag;
    split = bus8 && m_saver;
    pact = !cs_n && (!m_saver || prog_hit);
    ract = !cs_n && ram_hit;
    exp_pe = pact && (!split || !a0); exp_po = pact && (!split || a0);
    exp_re = ract && (!split || !a0); exp_ro = ract && (!split || a0);
    exp_rd = (reg_addr == 0) ? ((int'(m_toff) << 4) | (int'(m_saver) << 3)) : 0;
    ptag = cs_n ? "R4" : split ? "R7" : m_saver ? "R5" : "R3";
    rtag = cs_n ? "R4" : split ? "R7" : "R6";
    moved = (la_in != m_prev);
    stag = !m_toff ? "R8" : moved ? "R10" : "R9";
    check("R2", "rd_data", rd_data, exp_rd);
    check(ptag, "prog_en", {pe, po}, (exp_pe << 1) | exp_po);
    check(rtag, "ram_en", {re, ro}, (exp_re << 1) | exp_ro);
    check(stag, "la_sleep", la_sleep, int'(m_toff && !moved && m_quiet == N));
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int addr, int d);
    reg_addr = ADDR_W'(addr); wr_data = 8'(d); wr_en = 1; step(); wr_en = 0; reg_addr = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; #0.5;
    check("R1", "reset rd_data", rd_data, 0);
    step();
    // R3: saver off, all decode combinations with cs low
    cs_n = 0;
    for (int k = 0; k < 16; k++) begin
      {prog_hit, ram_hit, bus8, a0} = 4'(k); step();
    end
    // R4: chip deselected
    cs_n = 1;
    for (int k = 0; k < 16; k++) begin
      {prog_hit, ram_hit, bus8, a0} = 4'(k); step();
    end
    // R2: reserved bits, other addresses
    wr(0, 8'hFF); step(); wr(1, 8'h00); reg_addr = 1; step(); reg_addr = 3; step();
    reg_addr = 0; step(); wr(2, 8'h00); wr(0, 8'h08); step();
    // R5 / R6 / R7: saver on, every select/decode combination
    for (int k = 0; k < 32; k++) begin
      {cs_n, prog_hit, ram_hit, bus8, a0} = 5'(k); step();
    end
    // R8: turbo on, long quiet spell
    la_in = 4'h3; step(N + 4);
    // R9 / R10: turbo off
    wr(0, 8'h10);
    step(N + 3); la_in = 4'h5; step(2); la_in = 4'h6; step(N); step(2);
    la_in = 4'h6 ^ 4'h1; step(N + 2);
    wr(0, 8'h18);
    // Mixed random phase
    for (int k = 0; k < 600; k++) begin
      {cs_n, prog_hit, ram_hit, bus8, a0} = 5'($urandom);
      if ($urandom_range(0, 7) == 0) la_in = LA_W'($urandom);
      if ($urandom_range(0, 15) == 0) wr($urandom_range(0, 3), $urandom);
      else step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule